// File: doc/BRIEF.md
# Packed Three-Channel Small-Float to Single-Precision Expander

This block takes one 32-bit word that carries three unsigned small floating-point colour channels and turns each channel into an IEEE-754 single-precision value. Two channels are 11 bits wide (5-bit exponent, 6-bit mantissa). The third is 10 bits wide (5-bit exponent, 5-bit mantissa). A fourth output, alpha, is always the single-precision constant one. Every small exponent uses a bias of 15. No channel carries a sign.

The conversion keeps small-float denormals exactly. Each one is rewritten as a normalized single-precision number, with a leading-one detector choosing the shift. Infinities and NaNs keep their mantissa bits. Words enter through a valid/ready handshake. Results leave from one output register with a valid flag, and the sink can stall that register.

Top module: `packed_rgb_expander`

## Requirements
- R1: Channel 0 is taken from `in_word[10:0]` (mantissa bits 5:0, exponent bits 10:6). Channel 1 is taken from `in_word[21:11]` with the same layout. Channel 2 is taken from `in_word[31:22]` (mantissa bits 26:22, exponent bits 31:27). The channels appear on `out_r`, `out_g` and `out_b`.
- R2: A small exponent `e` with 0 < e < 31 gives the float32 exponent e+112. The small mantissa is placed at the top of the 23-bit float32 mantissa and the bits below it are zero.
- R3: A small exponent of 31 gives the float32 exponent 0xFF with the mantissa kept and aligned as in R2. A zero mantissa therefore gives +Inf and a nonzero mantissa gives a NaN.
- R4: A small exponent of 0 with a nonzero mantissa `m` of width W gives the exact value m·2^(−14−W) as a normalized float32. The exponent is 113−W+p, where p is the index of the highest set bit of m. The bits of m below p are placed at the top of the float32 mantissa.
- R5: A channel whose code is all zero gives +0.0 (0x00000000).
- R6: `out_a` is 0x3F800000 whenever `out_valid` is high. Bit 31 of every colour output is 0.
- R7: `in_ready` equals (!out_valid || out_ready). A word accepted on a clock edge appears on the outputs with `out_valid` high just after that edge.
- R8: While `out_valid` is high and `out_ready` is low, all outputs and `out_valid` hold their values.
- R9: While `rst` is high, and just after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 32 | Packed three-channel small-float word |
| out_valid | output | 1 | Output floats are valid |
| out_ready | input | 1 | Sink takes the output this cycle |
| out_r | output | 32 | Channel 0 as float32 |
| out_g | output | 32 | Channel 1 as float32 |
| out_b | output | 32 | Channel 2 as float32 |
| out_a | output | 32 | Alpha, constant 1.0 |

## Verification
Two things can happen on the same clock edge. The output register can release a held result to the sink while it loads the next decoded word. One word can also carry a denormal, a normal and a special code in different channels, so the three decode paths work at once. Random input-valid and output-ready patterns force cycles where release and load coincide, and cycles where the output is stalled. The 11-bit codes are swept one per word in channel 0 and inverted in channel 1, and the 10-bit codes are swept in channel 2, so each word mixes classes across channels. Every channel of every transfer is compared in order against a bench model that normalizes denormals by repeated shifting. The bench also checks the ready equation each cycle and checks that a stalled output does not move.

// File: rtl/rgbx_pkg.sv
package rgbx_pkg;
  localparam int F32_EXP_W  = 8;
  localparam int F32_MANT_W = 23;
  localparam int F32_BIAS   = 127;
  localparam logic [31:0] F32_ONE = 32'h3F80_0000;
  localparam int NUM_CH = 3;
endpackage

// File: rtl/lead_one_pos.sv
module lead_one_pos #(
  parameter int W  = 6,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/small_float_expand.sv
module small_float_expand
  import rgbx_pkg::*;
#(
  parameter int MANT_W = 6,
  parameter int EXP_W  = 5,
  localparam int CODE_W = MANT_W + EXP_W,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int ADJ    = F32_BIAS - BIAS,
  localparam int ALIGN  = F32_MANT_W - MANT_W,
  localparam int PW     = $clog2(MANT_W)
) (
  input  logic [CODE_W-1:0] code,
  output logic [31:0]       f32
);
  logic [EXP_W-1:0]     e;
  logic [MANT_W-1:0]    m;
  logic [PW-1:0]        lead;
  logic                 any_one;
  logic [2*MANT_W-1:0]  shifted;
  logic [MANT_W-1:0]    den_frac;
  logic [F32_EXP_W-1:0] den_exp;
  logic [F32_EXP_W-1:0] exp_o;
  logic [MANT_W-1:0]    frac_o;

  assign e = code[CODE_W-1:MANT_W];
  assign m = code[MANT_W-1:0];

  lead_one_pos #(.W(MANT_W)) u_lod (
    .vec  (m),
    .pos  (lead),
    .found(any_one)
  );

  // Move the leading one just above the kept fraction bits.
  assign shifted  = {{MANT_W{1'b0}}, m} << (MANT_W - int'(lead));
  assign den_frac = shifted[MANT_W-1:0];
  assign den_exp  = F32_EXP_W'(ADJ + 1 - MANT_W) + F32_EXP_W'(lead);

  always_comb begin
    if (e == '1) begin
      exp_o  = '1;
      frac_o = m;
    end else if (e != '0) begin
      exp_o  = F32_EXP_W'(e) + F32_EXP_W'(ADJ);
      frac_o = m;
    end else if (any_one) begin
      exp_o  = den_exp;
      frac_o = den_frac;
    end else begin
      exp_o  = '0;
      frac_o = '0;
    end
  end

  assign f32 = {1'b0, exp_o, frac_o, {ALIGN{1'b0}}};
endmodule

// File: rtl/pipe_reg_stage.sv
module pipe_reg_stage #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/packed_rgb_expander.sv
module packed_rgb_expander
  import rgbx_pkg::*;
#(
  parameter int CH0_MANT_W = 6,
  parameter int CH1_MANT_W = 6,
  parameter int CH2_MANT_W = 5,
  parameter int FLD_EXP_W  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_r,
  output logic [31:0] out_g,
  output logic [31:0] out_b,
  output logic [31:0] out_a
);
  logic [NUM_CH-1:0][31:0] dec;
  logic [NUM_CH-1:0][31:0] held;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int MW  = (c == 0) ? CH0_MANT_W : ((c == 1) ? CH1_MANT_W : CH2_MANT_W);
    localparam int LSB = (c == 0) ? 0 :
                         ((c == 1) ? CH0_MANT_W + FLD_EXP_W
                                   : CH0_MANT_W + CH1_MANT_W + 2 * FLD_EXP_W);
    small_float_expand #(.MANT_W(MW), .EXP_W(FLD_EXP_W)) u_exp (
      .code(in_word[LSB +: MW + FLD_EXP_W]),
      .f32 (dec[c])
    );
  end

  pipe_reg_stage #(.W(NUM_CH * 32)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (dec),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (held)
  );

  assign out_r = held[0];
  assign out_g = held[1];
  assign out_b = held[2];
  assign out_a = F32_ONE;
endmodule

// File: rtl/packed_rgb_expander_chk.sv
module packed_rgb_expander_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_r,
  input logic [31:0] out_g,
  input logic [31:0] out_b,
  input logic [31:0] out_a
);
  a_r7_ready_eq: assert property (@(posedge clk) disable iff (rst)
    in_ready == (!out_valid || out_ready));

  a_r7_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  a_r6_alpha_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_a == 32'h3F80_0000 && !out_r[31] && !out_g[31] && !out_b[31]));

  a_r5_zero_red: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[10:0] == 11'd0) |=> (out_r == 32'd0));

  a_r3_special_blue: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[31:27] == 5'h1F) |=> (out_b[30:23] == 8'hFF));

  a_r9_reset: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind packed_rgb_expander packed_rgb_expander_chk u_chk (.*);

// File: tb/tb_packed_rgb_expander.sv
module tb_packed_rgb_expander;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_r, out_g, out_b, out_a;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  localparam int NSWEEP = 2048;
  localparam int NTOTAL = NSWEEP + 400;

  always #5 clk = ~clk;

  packed_rgb_expander dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model: denormals normalized by shifting one bit at a time.
  function automatic logic [31:0] model(input int code, input int mw);
    int e = code >> mw;
    int m = code & ((1 << mw) - 1);
    int ex;
    if (e == 31) return {1'b0, 8'hFF, 23'(m << (23 - mw))};
    if (e != 0) return {1'b0, 8'(e + 112), 23'(m << (23 - mw))};
    if (m == 0) return 32'd0;
    ex = 113;
    while ((m & (1 << mw)) == 0) begin
      m = m << 1;
      ex = ex - 1;
    end
    m = m & ((1 << mw) - 1);
    return {1'b0, 8'(ex), 23'(m << (23 - mw))};
  endfunction

  function automatic string tag_of(input int code, input int mw, input int ch);
    int e = code >> mw;
    string s;
    if (e == 31) s = "R3";
    else if (e != 0) s = "R2";
    else if (code == 0) s = "R5";
    else s = "R4";
    return $sformatf("%s/R1 ch%0d code=%0h", s, ch, code);
  endfunction

  function automatic logic [31:0] gen(input int idx);
    if (idx < NSWEEP) return {10'(idx), ~11'(idx), 11'(idx)};
    case (idx - NSWEEP)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return {5'h1F, 5'h00, 5'h00, 6'h01, 5'h1E, 6'h3F};
      3: return {5'h00, 5'h10, 5'h1F, 6'h00, 5'h01, 6'h00};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] q[$];
    logic [31:0] w;
    logic [31:0] pr, pg, pb;
    bit stalled = 1'b0;
    int sent = 0;
    void'($urandom(32'd20240613));
    rst = 1'b1; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready === 1'b1, "R9 in_ready in reset", 32'(in_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 out_valid after reset", 32'(out_valid), 32'd0);

    while (sent < NTOTAL || q.size() > 0) begin
      @(negedge clk);
      in_valid  = (sent < NTOTAL) && ($urandom % 5 != 0);
      in_word   = gen(sent);
      out_ready = ($urandom % 10) < 7;
      #1;
      chk(in_ready === (!out_valid || out_ready), "R7 in_ready",
          32'(in_ready), 32'(!out_valid || out_ready));
      if (stalled) begin
        chk(out_valid === 1'b1 && out_r === pr && out_g === pg && out_b === pb,
            "R8 hold", out_r ^ out_g ^ out_b, pr ^ pg ^ pb);
      end
      stalled = out_valid && !out_ready;
      pr = out_r; pg = out_g; pb = out_b;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected output", out_r, 32'd0);
        end else begin
          w = q.pop_front();
          chk(out_r === model(int'(w[10:0]), 6), tag_of(int'(w[10:0]), 6, 0),
              out_r, model(int'(w[10:0]), 6));
          chk(out_g === model(int'(w[21:11]), 6), tag_of(int'(w[21:11]), 6, 1),
              out_g, model(int'(w[21:11]), 6));
          chk(out_b === model(int'(w[31:22]), 5), tag_of(int'(w[31:22]), 5, 2),
              out_b, model(int'(w[31:22]), 5));
          chk(out_a === 32'h3F80_0000, "R6 alpha", out_a, 32'h3F80_0000);
        end
      end
      if (in_valid && in_ready) begin
        q.push_back(in_word);
        sent++;
      end
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 drained", 32'(out_valid), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule